// File: doc/BRIEF.md
# Streaming Pixel Point-Operation Unit

This block processes a raster image delivered as a flat stream of samples, one pixel per clock while the input valid is high. Each sample carries a colour pixel (red, green, blue), an 8-bit gray pixel and a background pixel. One point operation is applied to every sample, and an 8-bit unsigned result comes out with its own valid strobe a fixed number of cycles later. There is no back-pressure. The output valid is the input valid delayed to line up with the result.

The available operations are weighted luminance from the colour channels, photographic negative, a fixed linear contrast stretch, binary thresholding against a constant, and subtraction of a co-located background pixel. A start-of-frame strobe that comes with a valid sample latches both the operation code and the threshold constant. Both then apply from that sample onward, so the operation cannot change in the middle of a frame.

Top module: `pix_point_unit`

## Requirements
- R1: The output valid equals the input valid delayed by exactly 3 clock cycles, with no gaps added or removed. Each valid input produces exactly one result.
- R2: When the latched code is 0, the result is (77*red + 151*green + 28*blue + 128) >> 8.
- R3: When the latched code is 1, the result is 255 minus the gray input, which is the same as its bitwise inversion.
- R4: When the latched code is 2, the result is 3*(gray - 127) + 112, computed signed and clamped to the range 0..255.
- R5: When the latched code is 3, the result is 255 if the gray input is greater than or equal to the latched constant, and 0 otherwise.
- R6: When the latched code is 4, the result is the gray input minus the background input, clamped to the range 0..255.
- R7: The operation code and the threshold constant are captured only on a valid sample with the start-of-frame strobe high. Changes to those inputs at any other time have no effect on results.
- R8: While reset is low and after it is released, the output valid is 0 and the result is 0 until the first valid sample has passed through the pipeline. Reset leaves the latched code at 0 and the constant at 0.
- R9: Latched codes 5, 6 and 7 pass the gray input through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample is valid this cycle |
| sof | input | 1 | First sample of a frame; latches the operation code and the constant |
| op_code | input | 3 | Operation select, captured on sof |
| thresh | input | 8 | Threshold constant, captured on sof |
| red | input | 8 | Red channel |
| green | input | 8 | Green channel |
| blue | input | 8 | Blue channel |
| gray | input | 8 | Gray pixel used by every operation except luminance |
| bgnd | input | 8 | Co-located background pixel |
| out_valid | output | 1 | Result is valid |
| out_pix | output | 8 | 8-bit unsigned result |

## Verification
The properties assume that in_valid is held low while reset is asserted. The latency property looks back three cycles and would otherwise see samples that reset discards. The per-operation properties tie each result to the code presented with a start-of-frame sample three cycles earlier, so they only apply to the first pixel of each frame. The stimulus keeps in_valid low throughout reset and opens every frame with a valid sof sample. It then changes op_code and thresh mid-frame without sof, inserts idle gaps between samples, and covers the clamp edges of the stretch and subtraction operations and a pixel equal to the threshold.

// File: rtl/pix_point_unit.sv
module pix_point_unit #(
  parameter int W      = 8,
  parameter int WR     = 77,
  parameter int WG     = 151,
  parameter int WB     = 28,
  parameter int GAIN   = 3,
  parameter int PIVOT  = 127,
  parameter int OFFS   = 112
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         sof,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] thresh,
  input  logic [W-1:0] red,
  input  logic [W-1:0] green,
  input  logic [W-1:0] blue,
  input  logic [W-1:0] gray,
  input  logic [W-1:0] bgnd,
  output logic         out_valid,
  output logic [W-1:0] out_pix
);
  localparam int MAXV = (1 << W) - 1;
  localparam int RND  = 1 << (W - 1);

  typedef enum logic [2:0] {OP_LUMA, OP_NEG, OP_STRETCH, OP_THRESH, OP_SUB} op_e;

  logic [2:0]   op_q;
  logic [W-1:0] thr_q;
  logic         v1, v2;
  logic [W-1:0] r1, g1, b1, y1, k1;
  logic [W-1:0] res_c, res2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= '0; thr_q <= '0; v1 <= 1'b0;
      r1 <= '0; g1 <= '0; b1 <= '0; y1 <= '0; k1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        r1 <= red; g1 <= green; b1 <= blue; y1 <= gray; k1 <= bgnd;
        if (sof) begin
          op_q  <= op_code;
          thr_q <= thresh;
        end
      end
    end
  end

  function automatic logic [W-1:0] clamp(input int x);
    if (x < 0)         return '0;
    else if (x > MAXV) return W'(MAXV);
    else               return W'(x);
  endfunction

  int luma, stretch, diff;
  always_comb begin
    luma    = (WR * int'(r1) + WG * int'(g1) + WB * int'(b1) + RND) >> W;
    stretch = GAIN * (int'(y1) - PIVOT) + OFFS;
    diff    = int'(y1) - int'(k1);
    case (op_q)
      OP_LUMA:    res_c = clamp(luma);
      OP_NEG:     res_c = ~y1;
      OP_STRETCH: res_c = clamp(stretch);
      OP_THRESH:  res_c = (y1 >= thr_q) ? W'(MAXV) : '0;
      OP_SUB:     res_c = clamp(diff);
      default:    res_c = y1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; res2 <= '0; out_valid <= 1'b0; out_pix <= '0;
    end else begin
      v2        <= v1;
      res2      <= res_c;
      out_valid <= v2;
      out_pix   <= res2;
    end
  end
endmodule

// File: rtl/pix_point_unit_chk.sv
module pix_point_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       sof,
  input logic [2:0] op_code,
  input logic [7:0] thresh,
  input logic [7:0] red,
  input logic [7:0] green,
  input logic [7:0] blue,
  input logic [7:0] gray,
  input logic [7:0] bgnd,
  input logic       out_valid,
  input logic [7:0] out_pix
);
  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 3));

  // R3
  negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && sof && op_code == 3'd1, 3) |-> out_pix == ~$past(gray, 3));

  // R5
  threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && sof && op_code == 3'd3, 3) |->
      out_pix == (($past(gray, 3) >= $past(thresh, 3)) ? 8'd255 : 8'd0));

  // R6
  subtract_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && sof && op_code == 3'd4, 3) |-> out_pix <= $past(gray, 3));

  // R2
  white_luma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && sof && op_code == 3'd0 && (red & green & blue) == 8'hFF, 3)
      |-> out_pix == 8'd255);

  // R8
  reset_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

bind pix_point_unit pix_point_unit_chk u_chk (.*);

// File: tb/tb_pix_point_unit.sv
module tb_pix_point_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, sof = 1'b0;
  logic [2:0] op_code = '0;
  logic [7:0] thresh = '0, red = '0, green = '0, blue = '0, gray = '0, bgnd = '0;
  logic       out_valid;
  logic [7:0] out_pix;

  int checks = 0, fails = 0;
  int m_op = 0, m_thr = 0;
  int   exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_point_unit dut (.*);

  function automatic int clampi(int x);
    return x < 0 ? 0 : (x > 255 ? 255 : x);
  endfunction

  function automatic int model(int op, int thr, int r, int g, int b, int y, int k);
    case (op)
      0: return (77*r + 151*g + 28*b + 128) / 256;
      1: return 255 - y;
      2: return clampi(3*(y - 127) + 112);
      3: return (y >= thr) ? 255 : 0;
      4: return clampi(y - k);
      default: return y;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(bit s, int op, int thr, int r, int g, int b, int y, int k, string tag);
    @(negedge clk);
    in_valid = 1; sof = s; op_code = 3'(op); thresh = 8'(thr);
    red = 8'(r); green = 8'(g); blue = 8'(b); gray = 8'(y); bgnd = 8'(k);
    if (s) begin m_op = op; m_thr = thr; end
    exp_q.push_back(model(m_op, m_thr, r, g, b, y, k));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; sof = 0;
      op_code = 3'(i + 3); thresh = 8'(i * 37);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) check("R1 unexpected valid", 1, 0);
        else check(tag_q.pop_front(), int'(out_pix), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R8 reset valid", int'(out_valid), 0);
    check("R8 reset pix", int'(out_pix), 0);
    @(negedge clk); rst_n = 1;
    idle(3);
    check("R8 idle after reset", int'(out_valid), 0);

    // R2 luminance
    send(1, 0, 0, 0, 0, 0, 9, 0, "R2");
    send(0, 0, 0, 255, 255, 255, 9, 0, "R2");
    send(0, 0, 0, 255, 0, 0, 9, 0, "R2");
    send(0, 0, 0, 0, 255, 0, 9, 0, "R2");
    send(0, 0, 0, 0, 0, 255, 9, 0, "R2");
    for (int i = 0; i < 8; i++) send(0, 0, 0, i*31, 200 - i*23, i*17 + 5, 0, 0, "R2");
    // R7: code changes mid-frame without sof must be ignored
    send(0, 1, 50, 100, 50, 25, 77, 0, "R7");
    idle(2);
    send(0, 3, 10, 10, 20, 30, 40, 0, "R7");

    // R3 negative
    send(1, 1, 0, 0, 0, 0, 0, 0, "R3");
    send(0, 1, 0, 0, 0, 0, 255, 0, "R3");
    for (int i = 0; i < 6; i++) send(0, 1, 0, 0, 0, 0, i*41 + 3, 0, "R3");

    // R4 stretch, clamp edges
    send(1, 2, 0, 0, 0, 0, 127, 0, "R4");
    send(0, 2, 0, 0, 0, 0, 90, 0, "R4");
    send(0, 2, 0, 0, 0, 0, 89, 0, "R4");
    send(0, 2, 0, 0, 0, 0, 0, 0, "R4");
    send(0, 2, 0, 0, 0, 0, 174, 0, "R4");
    send(0, 2, 0, 0, 0, 0, 175, 0, "R4");
    send(0, 2, 0, 0, 0, 0, 255, 0, "R4");

    // R5 threshold incl. equality; R7 constant change ignored
    send(1, 3, 100, 0, 0, 0, 100, 0, "R5");
    send(0, 3, 100, 0, 0, 0, 99, 0, "R5");
    send(0, 3, 100, 0, 0, 0, 101, 0, "R5");
    send(0, 3, 200, 0, 0, 0, 150, 0, "R7");
    idle(1);
    send(1, 3, 0, 0, 0, 0, 0, 0, "R5");
    send(1, 3, 255, 0, 0, 0, 254, 0, "R5");
    send(0, 3, 255, 0, 0, 0, 255, 0, "R5");

    // R6 background subtraction
    send(1, 4, 0, 0, 0, 0, 200, 50, "R6");
    send(0, 4, 0, 0, 0, 0, 50, 200, "R6");
    send(0, 4, 0, 0, 0, 0, 80, 80, "R6");
    send(0, 4, 0, 0, 0, 0, 255, 0, "R6");

    // R9 unused codes
    send(1, 5, 0, 1, 2, 3, 123, 9, "R9");
    send(1, 6, 0, 1, 2, 3, 7, 9, "R9");
    send(1, 7, 0, 1, 2, 3, 250, 9, "R9");

    // R1 gapped stream
    for (int i = 0; i < 10; i++) begin
      send(i == 0, 1, 0, 0, 0, 0, i*13, 0, "R1");
      if (i % 3 == 0) idle(i % 4 + 1);
    end
    idle(6);
    check("R1 all results delivered", exp_q.size(), 0);
    check("R1 valid low when idle", int'(out_valid), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule